// File: doc/BRIEF.md
# PME Retransmission Timer

This block drives the power-management event message of one downstream switch port. A qualifying hot-plug event raises a send request toward the message transmitter. A hot-plug event qualifies only if it arrives while the port, or the whole switch, is in the D3hot power state. The request stays up until the transmitter acknowledges it. The acknowledge sets the port's PME status bit, and from that point a countdown runs against a programmable timeout.

If software has not cleared the status bit by writing 1 before the timeout runs out, the message is requested again and the countdown restarts. A timeout of zero turns retransmission off.

When the link has gone into deep sleep after a turn-off message and a message is still outstanding, the block stops asking for transmission and instead holds a wakeup request. Once the link is active again, it drops the wakeup request and re-requests the message.

Top module: `pme_retx_ctrl`

## Requirements
- R1: After synchronous reset, `pme_req_o`, `wake_req_o` and `pme_status_o` are all 0.
- R2: When idle, a hot-plug event with `port_is_dsp_i`=1, either D3hot input at 1, and the link awake raises `pme_req_o` in the cycle after the event is sampled. An event without a downstream port or without D3hot raises nothing.
- R3: `pme_req_o` stays high until `msg_ack_i` is sampled with it. It then drops, and `pme_status_o` reads 1 from the next cycle.
- R4: With a nonzero timeout T and the status still set, `pme_req_o` rises again exactly T clock edges after the edge that sampled the acknowledge. Every later acknowledge restarts the same T-edge countdown.
- R5: With a timeout of 0, the message is never re-requested while the status stays set.
- R6: A status clear (`status_clr_i`=1) sampled while the status is 1 has three effects from the next cycle: the status reads 0, the countdown stops, and any pending re-request or wakeup request is dropped. A clear sampled during the first request, while the status is still 0, has no effect.
- R7: A link that is sampled asleep while a request or countdown is outstanding makes `wake_req_o` rise and `pme_req_o` stay low from the next cycle on.
- R8: `wake_req_o` is held while the link stays asleep. In the cycle after the link is sampled awake, it falls and `pme_req_o` rises.
- R9: Hot-plug events are ignored while a message is pending, being counted down or waiting on wakeup.
- R10: A qualifying hot-plug event that arrives while the link is asleep raises `wake_req_o`, not `pme_req_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| port_is_dsp_i | input | 1 | Port is a downstream port |
| port_d3hot_i | input | 1 | Port is in D3hot |
| switch_d3hot_i | input | 1 | Whole switch is in D3hot |
| hotplug_evt_i | input | 1 | Hot-plug event pulse |
| status_clr_i | input | 1 | Software write of 1 to the PME status bit |
| timeout_i | input | TIMEOUT_W | Retransmission timeout in clock cycles, 0 disables |
| msg_ack_i | input | 1 | Transmitter has sent the requested message |
| link_asleep_i | input | 1 | Link is in deep sleep after a turn-off message |
| pme_req_o | output | 1 | Request to send the PME message |
| wake_req_o | output | 1 | Request to wake the link |
| pme_status_o | output | 1 | PME status bit |

## Verification
Each result has a fixed cycle:
- The request, the wakeup request and the status all change in the cycle after the edge that samples the event, acknowledge, clear or sleep change that causes them.
- The only delay longer than one cycle is the retransmission, which lands exactly T edges after the acknowledge.

The bench keeps to these timings with a behavioural model that advances on each rising edge. All three outputs are compared against it at every falling edge. Stimulus changes shortly after the falling edge, so a late or early transition shows up as a mismatch in that exact cycle.

// File: rtl/pme_retx_pkg.sv
package pme_retx_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SEND = 2'd1,
        ST_WAIT = 2'd2,
        ST_WAKE = 2'd3
    } pme_st_e;

    typedef struct packed {
        logic is_dsp;
        logic port_d3hot;
        logic sw_d3hot;
        logic hp_event;
    } hp_ctx_t;

    function automatic logic hp_qualifies(hp_ctx_t c);
        return c.hp_event && c.is_dsp && (c.port_d3hot || c.sw_d3hot);
    endfunction

endpackage

// File: rtl/pme_retx_timer.sv
module pme_retx_timer #(
    parameter int TIMEOUT_W = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 run,
    input  logic [TIMEOUT_W-1:0] timeout,
    output logic                 expire
);
    localparam int CW = TIMEOUT_W + 1;

    logic [TIMEOUT_W-1:0] cnt;
    logic [CW-1:0]        cnt_inc;

    assign cnt_inc = {1'b0, cnt} + CW'(1);
    assign expire  = run && (timeout != '0) && (cnt_inc >= {1'b0, timeout});

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
        end else if (!cnt_inc[CW-1]) begin
            cnt <= cnt_inc[TIMEOUT_W-1:0];
        end
    end

endmodule

// File: rtl/pme_retx_fsm.sv
module pme_retx_fsm
    import pme_retx_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    trigger,
    input  logic    ack,
    input  logic    clr,
    input  logic    asleep,
    input  logic    expire,
    output pme_st_e state,
    output logic    status
);
    pme_st_e st_n;
    logic    stat_n;
    logic    clear_hit;

    assign clear_hit = clr && status;

    always_comb begin
        st_n   = state;
        stat_n = status;
        unique case (state)
            ST_IDLE: begin
                if (trigger) st_n = asleep ? ST_WAKE : ST_SEND;
            end
            ST_SEND: begin
                if (clear_hit) begin
                    st_n   = ST_IDLE;
                    stat_n = 1'b0;
                end else if (ack) begin
                    st_n   = ST_WAIT;
                    stat_n = 1'b1;
                end else if (asleep) begin
                    st_n = ST_WAKE;
                end
            end
            ST_WAIT: begin
                if (clear_hit) begin
                    st_n   = ST_IDLE;
                    stat_n = 1'b0;
                end else if (asleep) begin
                    st_n = ST_WAKE;
                end else if (expire) begin
                    st_n = ST_SEND;
                end
            end
            ST_WAKE: begin
                if (clear_hit) begin
                    st_n   = ST_IDLE;
                    stat_n = 1'b0;
                end else if (!asleep) begin
                    st_n = ST_SEND;
                end
            end
            default: st_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            status <= 1'b0;
        end else begin
            state  <= st_n;
            status <= stat_n;
        end
    end

endmodule

// File: rtl/pme_retx_ctrl.sv
module pme_retx_ctrl
    import pme_retx_pkg::*;
#(
    parameter int TIMEOUT_W = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 port_is_dsp_i,
    input  logic                 port_d3hot_i,
    input  logic                 switch_d3hot_i,
    input  logic                 hotplug_evt_i,
    input  logic                 status_clr_i,
    input  logic [TIMEOUT_W-1:0] timeout_i,
    input  logic                 msg_ack_i,
    input  logic                 link_asleep_i,
    output logic                 pme_req_o,
    output logic                 wake_req_o,
    output logic                 pme_status_o
);
    hp_ctx_t ctx;
    pme_st_e state;
    logic    trigger;
    logic    expire;
    logic    status;

    assign ctx = '{is_dsp:     port_is_dsp_i,
                   port_d3hot: port_d3hot_i,
                   sw_d3hot:   switch_d3hot_i,
                   hp_event:   hotplug_evt_i};
    assign trigger = hp_qualifies(ctx);

    pme_retx_timer #(.TIMEOUT_W(TIMEOUT_W)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .run     (state == ST_WAIT),
        .timeout (timeout_i),
        .expire  (expire)
    );

    pme_retx_fsm u_fsm (
        .clk     (clk),
        .rst     (rst),
        .trigger (trigger),
        .ack     (msg_ack_i),
        .clr     (status_clr_i),
        .asleep  (link_asleep_i),
        .expire  (expire),
        .state   (state),
        .status  (status)
    );

    assign pme_req_o    = (state == ST_SEND);
    assign wake_req_o   = (state == ST_WAKE);
    assign pme_status_o = status;

    // R7: sending and waking never requested together
    assert_req_wake_excl_R7: assert property (@(posedge clk) disable iff (rst)
        !(pme_req_o && wake_req_o));

    // R7: no send request in the cycle after the link is seen asleep
    assert_no_send_asleep_R7: assert property (@(posedge clk) disable iff (rst)
        link_asleep_i |=> !pme_req_o);

    // R3: request held until acknowledged
    assert_req_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (pme_req_o && !msg_ack_i && !status_clr_i && !link_asleep_i) |=> pme_req_o);

    // R3: acknowledge sets the status
    assert_ack_sets_R3: assert property (@(posedge clk) disable iff (rst)
        (pme_req_o && msg_ack_i && !(status_clr_i && pme_status_o)) |=> pme_status_o);

    // R6: clear of a set status drops everything
    assert_clear_R6: assert property (@(posedge clk) disable iff (rst)
        (status_clr_i && pme_status_o) |=> (!pme_status_o && !pme_req_o && !wake_req_o));

    // R5: zero timeout never re-requests during the countdown
    assert_zero_to_R5: assert property (@(posedge clk) disable iff (rst)
        (timeout_i == '0 && pme_status_o && !pme_req_o && !wake_req_o && !link_asleep_i)
        |=> !pme_req_o);

    // R8: wakeup held while link stays asleep
    assert_wake_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (wake_req_o && link_asleep_i && !(status_clr_i && pme_status_o)) |=> wake_req_o);

endmodule

// File: tb/sim_pme_retx_ctrl.sv
`timescale 1ns/1ps
module sim_pme_retx_ctrl;
    localparam int TW = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic dsp = 1'b0, pd3 = 1'b0, sd3 = 1'b0, hp = 1'b0, clr = 1'b0;
    logic ack = 1'b0, asleep = 1'b0;
    logic [TW-1:0] tmo = 16'd5;
    logic req, wake, stat;

    int n_checks = 0;
    int n_errors = 0;
    int cyc = 0;
    string cur_req = "R1";

    // reference model state
    bit m_req = 0, m_wake = 0, m_status = 0, m_wait = 0;
    int ack_cyc = 0;

    always #10 clk = ~clk;

    pme_retx_ctrl #(.TIMEOUT_W(TW)) u0 (
        .clk(clk), .rst(rst), .port_is_dsp_i(dsp), .port_d3hot_i(pd3),
        .switch_d3hot_i(sd3), .hotplug_evt_i(hp), .status_clr_i(clr),
        .timeout_i(tmo), .msg_ack_i(ack), .link_asleep_i(asleep),
        .pme_req_o(req), .wake_req_o(wake), .pme_status_o(stat)
    );

    always @(posedge clk) begin
        bit clear_hit;
        cyc = cyc + 1;
        clear_hit = clr && m_status;
        if (rst) begin
            m_req = 0; m_wake = 0; m_status = 0; m_wait = 0;
        end else if (m_req) begin
            if (clear_hit) begin m_req = 0; m_status = 0; end
            else if (ack) begin m_req = 0; m_status = 1; m_wait = 1; ack_cyc = cyc; end
            else if (asleep) begin m_req = 0; m_wake = 1; end
        end else if (m_wake) begin
            if (clear_hit) begin m_wake = 0; m_status = 0; end
            else if (!asleep) begin m_wake = 0; m_req = 1; end
        end else if (m_wait) begin
            if (clear_hit) begin m_wait = 0; m_status = 0; end
            else if (asleep) begin m_wait = 0; m_wake = 1; end
            else if (tmo != 0 && (cyc - ack_cyc) >= int'(tmo)) begin m_wait = 0; m_req = 1; end
        end else begin
            if (hp && dsp && (pd3 || sd3)) begin
                if (asleep) m_wake = 1; else m_req = 1;
            end
        end
    end

    task automatic check1(string what, logic act, bit exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s at cycle %0d: actual %b expected %b", cur_req, what, cyc, act, exp);
        end
    endtask

    always @(negedge clk) begin
        check1("pme_req_o", req, m_req);
        check1("wake_req_o", wake, m_wake);
        check1("pme_status_o", stat, m_status);
    end

    task automatic step(int n);
        repeat (n) @(negedge clk);
        #2;
    endtask

    task automatic pulse_hp();  hp = 1;  step(1); hp = 0;  endtask
    task automatic pulse_ack(); ack = 1; step(1); ack = 0; endtask
    task automatic pulse_clr(); clr = 1; step(1); clr = 0; endtask

    task automatic finish_up();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog expired at cycle %0d: actual running expected done", cyc);
        finish_up();
    end

    initial begin
        step(3);
        rst = 0;
        cur_req = "R1"; step(2);

        // R2: unqualified events raise nothing
        cur_req = "R2";
        dsp = 1; pd3 = 0; sd3 = 0; pulse_hp(); step(3);
        dsp = 0; pd3 = 1; pulse_hp(); step(3);

        // R2 / R3: qualified event, request held until ack
        cur_req = "R3";
        dsp = 1; pd3 = 1; pulse_hp(); step(4);
        pulse_ack();
        // R4: re-request after T=5 edges, then restart
        cur_req = "R4"; step(12);
        pulse_ack(); step(1);
        // R9: event during countdown ignored
        cur_req = "R9"; pulse_hp(); step(3);
        // R6: clear during countdown
        cur_req = "R6"; pulse_clr(); step(10);

        // R6: clear in first send ignored, clear in re-send cancels
        pulse_hp(); step(2);
        pulse_clr(); step(2);
        pulse_ack(); step(5);
        pulse_clr(); step(5);

        // R5: zero timeout, switch-level D3hot
        cur_req = "R5";
        tmo = 16'd0; pd3 = 0; sd3 = 1;
        pulse_hp(); step(2);
        pulse_ack(); step(30);
        pulse_clr(); step(2);

        // R7 / R8: sleep escalation and resend
        cur_req = "R7";
        tmo = 16'd8;
        pulse_hp(); step(2);
        pulse_ack(); step(3);
        asleep = 1; step(6);
        cur_req = "R8";
        asleep = 0; step(3);
        pulse_ack(); step(2);
        pulse_clr(); step(3);

        // R7: sleep while first request is pending
        cur_req = "R7";
        pulse_hp(); step(2);
        asleep = 1; step(3);
        asleep = 0; step(2);
        pulse_ack(); step(2);
        pulse_clr(); step(3);

        // R10: event while asleep
        cur_req = "R10";
        asleep = 1; pulse_hp(); step(4);
        asleep = 0; step(2);
        pulse_ack(); step(2);
        pulse_clr(); step(3);

        finish_up();
    end

endmodule